// File: doc/BRIEF.md
# Three-Channel Match/Reload Timer Bank

This peripheral holds three independent 32-bit timers behind one word-addressed register window. Each channel has a live count register that software can overwrite, a reload value, and two compare registers. One packed control word gives each channel a run bit, a source select and an overflow-interrupt enable. A single direction bit in the same word makes every channel count either up or down. A channel steps either once per bus clock or once per rising edge of an external clock input. That input is brought into the bus clock domain by a two-stage synchronizer followed by an edge detector.

When a step takes a channel past its end of range, it restarts from its reload value and raises an overflow event. The end of range is zero when counting down and all ones when counting up. A step that lands exactly on a compare value raises a match event. Events collect in a sticky status word that software clears by writing ones. A mask word decides which status bits drive the single interrupt line. The usual setup is a periodic tick: load a reload value, enable the channel with overflow interrupts, and service the interrupt every reload+1 steps.

Top module: `tri_timer_bank`

## Requirements
- R1: After reset, every count, reload, compare, control, status and mask register reads zero and `irq` is low.
- R2: Word addresses: channel n (n=0,1,2) occupies 0x10*n, with count at +0x0, reload at +0x4, compare A at +0x8 and compare B at +0xC. Control is at 0x30, status at 0x34 and mask at 0x38. Every register reads back what was last written, and a write to count replaces the live value.
- R3: Control bits 3n, 3n+1 and 3n+2 are channel n's run, source-select and overflow-enable. With run=1 and source=0, the channel steps once per bus clock. Clearing run freezes the count, and setting it again resumes from the held value.
- R4: Control bit 9 = 1 makes all channels count up (+1 per step); bit 9 = 0 makes them count down (-1 per step).
- R5: A down-counting channel stepping from zero loads its reload value and raises an overflow event, so overflows recur every reload+1 steps.
- R6: An up-counting channel stepping from 0xFFFFFFFF loads its reload value and raises an overflow event.
- R7: The overflow status bit of a channel is set only while that channel's overflow-enable bit is 1.
- R8: Status bits 3n, 3n+1 and 3n+2 are channel n's compare-A match, compare-B match and overflow. A match bit is set when a step makes the count equal to the compare value. A software write to count that equals a compare value sets nothing.
- R9: Status bits are sticky. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R10: `irq` is high exactly when some status bit is 1 and its mask bit is 0.
- R11: With source=1, a channel steps exactly once per rising edge of `ext_clk` and ignores bus clocks between edges.
- R12: The channels are independent: running or matching one changes neither the count nor the status bits of another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid during a read strobe, otherwise zero |
| ext_clk | input | 1 | Asynchronous external step source |
| irq | output | 1 | Interrupt request, OR of unmasked status |

## Verification
The bench counts a channel through zero and through all ones and checks that the count lands exactly on the reload value. A design that reloaded one step late, or that wrapped to zero, would show a count off by one and a wrong overflow period. It stops and restarts a channel and expects the held value to survive. A design that cleared or kept stepping would read a different number. Three further checks each target one specific bug. A write of zeros to status must not clear it, which a design that overwrote status on any write would fail. A software count write equal to a compare value must set nothing, which a design that compared the count at every cycle would fail. Several bus clocks pass between each external edge, so a design that stepped on the level of `ext_clk`, or on every clock, would end far below the expected count.

// File: rtl/ttb_pkg.sv
package ttb_pkg;
    localparam int N_TMR        = 3;
    localparam int CNT_W        = 32;
    localparam int ADDR_W       = 6;
    localparam int IDX_W        = ADDR_W - 2;
    localparam int FLD_PER_TMR  = 3;
    localparam int REGS_PER_TMR = 4;
    localparam int DIR_BIT      = N_TMR * FLD_PER_TMR;
    localparam int CTRL_W       = DIR_BIT + 1;
    localparam int STS_W        = N_TMR * FLD_PER_TMR;
    localparam int IDX_CTRL     = 12;
    localparam int IDX_STS      = 13;
    localparam int IDX_MASK     = 14;
    localparam int SYNC_STAGES  = 2;

    // register slot inside one channel's window
    typedef enum logic [1:0] {
        SLOT_CNT  = 2'd0,
        SLOT_LOAD = 2'd1,
        SLOT_CMPA = 2'd2,
        SLOT_CMPB = 2'd3
    } slot_e;

    // per-channel control field, run in the lowest bit
    typedef struct packed {
        logic ovf_en;
        logic src_ext;
        logic run;
    } tmr_ctl_t;

    // per-channel event group, compare A in the lowest bit
    typedef struct packed {
        logic ovf;
        logic hit_b;
        logic hit_a;
    } tmr_evt_t;

    function automatic logic [IDX_W-1:0] slot_idx(input int chan, input slot_e s);
        return IDX_W'(chan * REGS_PER_TMR + int'(s));
    endfunction
endpackage

// File: rtl/ttb_edge_sync.sv
module ttb_edge_sync #(
    parameter int STAGES = ttb_pkg::SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic tick_o
);
    // STAGES synchronizer flops plus one history flop for the edge detector
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[STAGES-1:0], async_i};
    end

    assign tick_o = sh_q[STAGES-1] & ~sh_q[STAGES];

    // a level held high on the input must not produce back-to-back steps
    assert_single_step_R11: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);
endmodule

// File: rtl/ttb_counter.sv
module ttb_counter #(
    parameter int CNT_W = ttb_pkg::CNT_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 step_i,
    input  logic                 up_i,
    input  logic                 ovf_en_i,
    input  logic                 ld_i,
    input  logic [CNT_W-1:0]     ld_val_i,
    input  logic [CNT_W-1:0]     reload_i,
    input  logic [CNT_W-1:0]     cmp_a_i,
    input  logic [CNT_W-1:0]     cmp_b_i,
    output logic [CNT_W-1:0]     cnt_o,
    output ttb_pkg::tmr_evt_t    evt_o
);
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0] TOP  = '1;
    localparam logic [CNT_W-1:0] ZERO = '0;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] nxt;
    logic             wrap;
    logic             take;

    always_comb begin
        wrap = up_i ? (cnt_q == TOP) : (cnt_q == ZERO);
        if (wrap)      nxt = reload_i;
        else if (up_i) nxt = cnt_q + ONE;
        else           nxt = cnt_q - ONE;
    end

    // software load wins over a step in the same cycle
    assign take = step_i && !ld_i;

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (ld_i) cnt_q <= ld_val_i;
        else if (step_i) cnt_q <= nxt;
    end

    always_comb begin
        evt_o.hit_a = take && (nxt == cmp_a_i);
        evt_o.hit_b = take && (nxt == cmp_b_i);
        evt_o.ovf   = take && wrap && ovf_en_i;
    end

    assign cnt_o = cnt_q;

    assert_hold_when_idle_R3: assert property (@(posedge clk) disable iff (rst)
        (!step_i && !ld_i) |=> $stable(cnt_q));

    assert_down_step_R3: assert property (@(posedge clk) disable iff (rst)
        (take && !up_i && cnt_q != ZERO) |=> (cnt_q == $past(cnt_q) - ONE));

    assert_wrap_reload_R5: assert property (@(posedge clk) disable iff (rst)
        (take && wrap) |=> (cnt_q == $past(reload_i)));
endmodule

// File: rtl/ttb_irq.sv
module ttb_irq #(
    parameter int W = ttb_pkg::STS_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] evt_i,
    input  logic         sts_wr_i,
    input  logic         mask_wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] sts_o,
    output logic [W-1:0] mask_o,
    output logic         irq_o
);
    logic [W-1:0] sts_q;
    logic [W-1:0] mask_q;
    logic [W-1:0] clr;

    assign clr = sts_wr_i ? wdata_i : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            sts_q  <= '0;
            mask_q <= '0;
        end else begin
            // a new event outranks a clear of the same bit
            sts_q <= (sts_q & ~clr) | evt_i;
            if (mask_wr_i) mask_q <= wdata_i;
        end
    end

    assign sts_o  = sts_q;
    assign mask_o = mask_q;
    assign irq_o  = |(sts_q & ~mask_q);

    assert_event_sticks_R8: assert property (@(posedge clk) disable iff (rst)
        (|evt_i) |=> ((sts_q & $past(evt_i)) == $past(evt_i)));

    assert_w1c_clears_R9: assert property (@(posedge clk) disable iff (rst)
        (sts_wr_i && |(wdata_i & ~evt_i)) |=> ((sts_q & $past(wdata_i & ~evt_i)) == '0));
endmodule

// File: rtl/tri_timer_bank.sv
module tri_timer_bank #(
    parameter int N_TMR  = ttb_pkg::N_TMR,
    parameter int CNT_W  = ttb_pkg::CNT_W,
    parameter int ADDR_W = ttb_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic              ext_clk,
    output logic              irq
);
    import ttb_pkg::*;

    localparam int IW     = ADDR_W - 2;
    localparam int FLD    = FLD_PER_TMR;
    localparam int DIRB   = N_TMR * FLD;
    localparam int CW     = DIRB + 1;
    localparam int SW     = N_TMR * FLD;

    logic [IW-1:0]    widx;
    logic             aligned;
    logic             wr;
    logic             rd;
    logic [CW-1:0]    ctrl_q;
    logic [CNT_W-1:0] load_q [N_TMR];
    logic [CNT_W-1:0] cmpa_q [N_TMR];
    logic [CNT_W-1:0] cmpb_q [N_TMR];
    logic [CNT_W-1:0] cnt    [N_TMR];
    logic [SW-1:0]    evt_all;
    logic [SW-1:0]    sts;
    logic [SW-1:0]    mask;
    logic             ext_tick;
    logic             count_up;
    logic [CNT_W-1:0] rd_val;

    assign widx     = bus_addr[ADDR_W-1:2];
    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign wr       = bus_en && bus_we && aligned;
    assign rd       = bus_en && !bus_we && aligned;
    assign count_up = ctrl_q[DIRB];

    ttb_edge_sync #(.STAGES(SYNC_STAGES)) u_ext (
        .clk     (clk),
        .rst     (rst),
        .async_i (ext_clk),
        .tick_o  (ext_tick)
    );

    // shared control word and per-channel setting registers
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            for (int t = 0; t < N_TMR; t++) begin
                load_q[t] <= '0;
                cmpa_q[t] <= '0;
                cmpb_q[t] <= '0;
            end
        end else if (wr) begin
            if (widx == IW'(IDX_CTRL)) ctrl_q <= bus_wdata[CW-1:0];
            for (int t = 0; t < N_TMR; t++) begin
                if (widx == IW'(t * REGS_PER_TMR + int'(SLOT_LOAD))) load_q[t] <= bus_wdata;
                if (widx == IW'(t * REGS_PER_TMR + int'(SLOT_CMPA))) cmpa_q[t] <= bus_wdata;
                if (widx == IW'(t * REGS_PER_TMR + int'(SLOT_CMPB))) cmpb_q[t] <= bus_wdata;
            end
        end
    end

    for (genvar g = 0; g < N_TMR; g++) begin : g_chan
        tmr_ctl_t ctl;
        tmr_evt_t evt;
        logic     step;
        logic     ld;

        assign ctl  = tmr_ctl_t'(ctrl_q[g*FLD +: FLD]);
        assign step = ctl.run && (ctl.src_ext ? ext_tick : 1'b1);
        assign ld   = wr && (widx == IW'(g * REGS_PER_TMR + int'(SLOT_CNT)));

        ttb_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk      (clk),
            .rst      (rst),
            .step_i   (step),
            .up_i     (count_up),
            .ovf_en_i (ctl.ovf_en),
            .ld_i     (ld),
            .ld_val_i (bus_wdata),
            .reload_i (load_q[g]),
            .cmp_a_i  (cmpa_q[g]),
            .cmp_b_i  (cmpb_q[g]),
            .cnt_o    (cnt[g]),
            .evt_o    (evt)
        );

        assign evt_all[g*FLD +: FLD] = evt;
    end

    ttb_irq #(.W(SW)) u_irq (
        .clk       (clk),
        .rst       (rst),
        .evt_i     (evt_all),
        .sts_wr_i  (wr && (widx == IW'(IDX_STS))),
        .mask_wr_i (wr && (widx == IW'(IDX_MASK))),
        .wdata_i   (bus_wdata[SW-1:0]),
        .sts_o     (sts),
        .mask_o    (mask),
        .irq_o     (irq)
    );

    always_comb begin
        rd_val = '0;
        if (widx == IW'(IDX_CTRL)) rd_val = CNT_W'(ctrl_q);
        if (widx == IW'(IDX_STS))  rd_val = CNT_W'(sts);
        if (widx == IW'(IDX_MASK)) rd_val = CNT_W'(mask);
        for (int t = 0; t < N_TMR; t++) begin
            if (widx == IW'(t * REGS_PER_TMR + int'(SLOT_CNT)))  rd_val = cnt[t];
            if (widx == IW'(t * REGS_PER_TMR + int'(SLOT_LOAD))) rd_val = load_q[t];
            if (widx == IW'(t * REGS_PER_TMR + int'(SLOT_CMPA))) rd_val = cmpa_q[t];
            if (widx == IW'(t * REGS_PER_TMR + int'(SLOT_CMPB))) rd_val = cmpb_q[t];
        end
    end

    assign bus_rdata = rd ? rd_val : '0;

    // the interrupt line must fall once every pending bit is masked or cleared
    assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        ((sts & ~mask) == '0) |-> !irq);
endmodule

// File: tb/test_tri_timer_bank.sv
module test_tri_timer_bank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ext_clk = 1'b0;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } exp_item_t;
    exp_item_t sb_q[$];

    always #2 clk = ~clk;

    tri_timer_bank i_tri_timer_bank (
        .clk       (clk),
        .rst       (rst),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ext_clk   (ext_clk),
        .irq       (irq)
    );

    // monitor: every read strobe pops one expected item
    always @(negedge clk) begin
        if (!rst && bus_en && !bus_we) begin
            if (sb_q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL scoreboard: read with no expected item, actual %h", bus_rdata);
            end else begin
                exp_item_t it;
                it = sb_q.pop_front();
                n_chk++;
                if (bus_rdata !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: addr %h actual %h expected %h", it.tag, bus_addr, bus_rdata, it.exp);
                end
            end
        end
    end

    // all tasks start and end 1 ns after a rising edge
    task automatic wr_reg(input logic [5:0] a, input logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd_exp(input logic [5:0] a, input logic [31:0] e, input string tag);
        exp_item_t it;
        it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(posedge clk); #1;
        bus_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic chk_irq(input logic e, input string tag);
        n_chk++;
        if (irq !== e) begin
            n_fail++;
            $display("FAIL %s: irq actual %b expected %b", tag, irq, e);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        idle(1);

        // R1 reset values
        rd_exp(6'h30, 32'h0, "R1 ctrl");
        rd_exp(6'h00, 32'h0, "R1 count0");
        rd_exp(6'h24, 32'h0, "R1 load2");
        rd_exp(6'h34, 32'h0, "R1 status");
        rd_exp(6'h38, 32'h0, "R1 mask");
        chk_irq(1'b0, "R1 irq");

        // R2 address map and readback
        wr_reg(6'h00, 32'h1234_5678);
        rd_exp(6'h00, 32'h1234_5678, "R2 count0");
        wr_reg(6'h14, 32'h0000_A5A5);
        rd_exp(6'h14, 32'h0000_A5A5, "R2 load1");
        wr_reg(6'h2C, 32'h0000_0077);
        rd_exp(6'h2C, 32'h0000_0077, "R2 cmpb2");

        wr_reg(6'h08, 32'h50);   wr_reg(6'h0C, 32'h60);
        wr_reg(6'h18, 32'h1000); wr_reg(6'h1C, 32'h1000);
        wr_reg(6'h28, 32'h1000); wr_reg(6'h2C, 32'h5);

        // R3 run, freeze, resume: write run, idle 4, clear run -> 5 steps
        wr_reg(6'h00, 32'd200);
        wr_reg(6'h30, 32'h1);
        idle(4);
        wr_reg(6'h30, 32'h0);
        rd_exp(6'h00, 32'd195, "R3 down count");
        idle(3);
        rd_exp(6'h00, 32'd195, "R3 frozen");
        wr_reg(6'h30, 32'h1);
        idle(2);
        wr_reg(6'h30, 32'h0);
        rd_exp(6'h00, 32'd192, "R3 resumed");
        rd_exp(6'h34, 32'h0, "R3 no events");

        // R4 up counting: 4 steps
        wr_reg(6'h00, 32'd10);
        wr_reg(6'h30, 32'h201);
        idle(3);
        wr_reg(6'h30, 32'h200);
        rd_exp(6'h00, 32'd14, "R4 up count");

        // R5 down reload: reload 2, count 1, two steps 1->0->2
        wr_reg(6'h04, 32'd2);
        wr_reg(6'h00, 32'd1);
        wr_reg(6'h30, 32'h5);
        idle(1);
        wr_reg(6'h30, 32'h0);
        rd_exp(6'h00, 32'd2, "R5 reloaded");
        rd_exp(6'h34, 32'h4, "R5 overflow bit");
        chk_irq(1'b1, "R10 irq on overflow");
        // R9 writing zeros to the pending bit keeps it
        wr_reg(6'h34, 32'h3);
        rd_exp(6'h34, 32'h4, "R9 w0 keeps");
        wr_reg(6'h34, 32'h4);
        rd_exp(6'h34, 32'h0, "R9 w1 clears");
        chk_irq(1'b0, "R9 irq after clear");
        // R5 period: two steps 2->1->0 no overflow, third step overflows
        wr_reg(6'h30, 32'h5);
        idle(1);
        wr_reg(6'h30, 32'h0);
        rd_exp(6'h00, 32'd0, "R5 at zero");
        rd_exp(6'h34, 32'h0, "R5 no early overflow");
        wr_reg(6'h30, 32'h5);
        wr_reg(6'h30, 32'h0);
        rd_exp(6'h00, 32'd2, "R5 period reload");
        rd_exp(6'h34, 32'h4, "R5 period overflow");
        wr_reg(6'h34, 32'h4);

        // R7 overflow with enable off sets nothing
        wr_reg(6'h00, 32'd1);
        wr_reg(6'h30, 32'h1);
        idle(1);
        wr_reg(6'h30, 32'h0);
        rd_exp(6'h00, 32'd2, "R7 reloaded");
        rd_exp(6'h34, 32'h0, "R7 no overflow bit");
        chk_irq(1'b0, "R7 irq low");

        // R8 compare A hit after 3 steps 0x53 -> 0x50
        wr_reg(6'h00, 32'h53);
        wr_reg(6'h30, 32'h1);
        idle(2);
        wr_reg(6'h30, 32'h0);
        rd_exp(6'h00, 32'h50, "R8 count at compare");
        rd_exp(6'h34, 32'h1, "R8 compare A bit");
        // R10 masking
        wr_reg(6'h38, 32'h1);
        chk_irq(1'b0, "R10 masked");
        rd_exp(6'h38, 32'h1, "R10 mask readback");
        wr_reg(6'h38, 32'h1FE);
        chk_irq(1'b1, "R10 other bits masked");
        wr_reg(6'h38, 32'h0);
        wr_reg(6'h34, 32'h1);
        // R8 software load equal to compare sets nothing
        wr_reg(6'h00, 32'h60);
        rd_exp(6'h34, 32'h0, "R8 sw load no match");

        // R6 up wrap: 0xFFFFFFFE -> 0xFFFFFFFF -> reload 7
        wr_reg(6'h04, 32'd7);
        wr_reg(6'h00, 32'hFFFF_FFFE);
        wr_reg(6'h30, 32'h205);
        idle(1);
        wr_reg(6'h30, 32'h200);
        rd_exp(6'h00, 32'd7, "R6 wrap reload");
        rd_exp(6'h34, 32'h4, "R6 overflow bit");
        wr_reg(6'h34, 32'h4);

        // R11 external source on channel 1: 4 rising edges
        wr_reg(6'h10, 32'd50);
        wr_reg(6'h30, 32'h18);
        for (int k = 0; k < 4; k++) begin
            ext_clk = 1'b1; idle(5);
            ext_clk = 1'b0; idle(5);
        end
        idle(4);
        wr_reg(6'h30, 32'h0);
        rd_exp(6'h10, 32'd46, "R11 external steps");
        rd_exp(6'h00, 32'd7, "R12 channel0 untouched");

        // R12 channel 2 compare B hit: 7 -> 6 -> 5
        wr_reg(6'h20, 32'd7);
        wr_reg(6'h30, 32'h40);
        idle(1);
        wr_reg(6'h30, 32'h0);
        rd_exp(6'h20, 32'd5, "R12 channel2 count");
        rd_exp(6'h34, 32'h80, "R12 channel2 compare B bit");
        rd_exp(6'h10, 32'd46, "R12 channel1 untouched");
        chk_irq(1'b1, "R12 irq");
        wr_reg(6'h34, 32'h80);
        chk_irq(1'b0, "R9 final clear");

        idle(3);
        n_chk++;
        if (sb_q.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard: %0d items left, expected 0", sb_q.size());
        end
        finish_run();
    end
endmodule